// File: doc/BRIEF.md
# Banked Single-Port SRAM with Segmented Wordlines

This block is a synthesizable single-port memory whose storage is divided into equal banks. Each bank row is further divided into word groups, and every group has its own local wordline enable. An access asserts exactly one bank and, inside that bank, exactly one group of the addressed row. Every other bank and every other group of the shared row stays inactive, so the load switched per access is a small fraction of the array.

Each access splits its address into four fields. The bank select and the group select are brought out as activity vectors, so a testbench or a power estimator can see which part of the array was driven. Reads return registered data one clock after the request. Writes change only the addressed word.

Top module: `banked_sram`

## Requirements
- R1: The address is read as the fields {bank, row, group, word} from MSB to LSB. With the default sizes these are addr[7:6], addr[5:3], addr[2:1] and addr[0].
- R2: While `req` is high and `rst` is low, `bank_en` has exactly one bit set, and its index equals the bank field.
- R3: While `req` is high and `rst` is low, `grp_en` has exactly one bit set, and its index equals the group field.
- R4: While `req` is low, `bank_en` and `grp_en` are both all-zero.
- R5: While `rst` is high, `bank_en` and `grp_en` are all-zero whatever `req` is, and `rdata` is cleared to zero.
- R6: A request with `we` high stores `wdata` at the addressed word only. Every other word keeps its value, including the other words and groups of the same row and the same location in other banks.
- R7: A request with `we` low presents the stored word on `rdata` after the next rising clock edge.
- R8: `rdata` keeps its value across cycles with no read request, which covers both write cycles and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address {bank,row,group,word} |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| bank_en | output | 4 | One-hot bank activity |
| grp_en | output | 4 | One-hot word-group activity |

## Verification
The hardest fault to observe is a write that also reaches a neighbour: another word or group of the same row, or the same location in another bank. Nothing at the ports shows such a side effect unless the disturbed word is read back afterwards. The stimulus first fills every address with a distinct value. It then overwrites single words and reads back the whole row of every bank at that row index, which exposes any leak outside the selected group or bank.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic rst, input logic req, input logic we);
        if (rst || !req) return ACC_IDLE;
        return we ? ACC_WRITE : ACC_READ;
    endfunction

    function automatic int field_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sram_addr_split.sv
module sram_addr_split
    import sram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROWS      = 8,
    parameter int GROUPS    = 4,
    parameter int WPG       = 2,
    localparam int BANK_W   = field_w(NUM_BANKS),
    localparam int ROW_W    = field_w(ROWS),
    localparam int GRP_W    = field_w(GROUPS),
    localparam int WORD_W   = field_w(WPG),
    localparam int ADDR_W   = BANK_W + ROW_W + GRP_W + WORD_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank_idx,
    output logic [ROW_W-1:0]  row_idx,
    output logic [GRP_W-1:0]  grp_idx,
    output logic [WORD_W-1:0] word_idx
);
    always_comb begin
        {bank_idx, row_idx, grp_idx, word_idx} = addr;
    end
endmodule

// File: rtl/sram_bank_select.sv
module sram_bank_select
    import sram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = field_w(NUM_BANKS)
) (
    input  acc_kind_e         kind,
    input  logic [BANK_W-1:0] bank_idx,
    output logic [NUM_BANKS-1:0] bank_en
);
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        assign bank_en[k] = (kind != ACC_IDLE) && (bank_idx == BANK_W'(k));
    end
endmodule

// File: rtl/sram_wordline_gate.sv
module sram_wordline_gate
    import sram_bank_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int GROUPS  = 4,
    localparam int ROW_W  = field_w(ROWS),
    localparam int GRP_W  = field_w(GROUPS),
    localparam int LINES  = ROWS * GROUPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bank_on,
    input  logic [ROW_W-1:0] row_idx,
    input  logic [GRP_W-1:0] grp_idx,
    output logic [LINES-1:0] local_wl,
    output logic [GROUPS-1:0] grp_act
);
    logic [ROWS-1:0]   row_line;
    logic [GROUPS-1:0] grp_dec;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_line[r] = bank_on && (row_idx == ROW_W'(r));
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_dec[g] = (grp_idx == GRP_W'(g));
    end

    // local group driver gated by the global row line
    for (genvar r = 0; r < ROWS; r++) begin : g_lr
        for (genvar g = 0; g < GROUPS; g++) begin : g_lg
            assign local_wl[r*GROUPS+g] = row_line[r] && grp_dec[g];
        end
    end

    always_comb begin
        grp_act = '0;
        for (int r = 0; r < ROWS; r++) begin
            grp_act = grp_act | local_wl[r*GROUPS +: GROUPS];
        end
    end

    // R3: at most one local wordline segment is driven in a bank
    p_single_segment_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(local_wl) <= 1);

    // R2: an idle bank drives no segment
    p_idle_bank_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !bank_on |-> (local_wl == '0));
endmodule

// File: rtl/sram_bank_array.sv
module sram_bank_array
    import sram_bank_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int GROUPS  = 4,
    parameter int WPG     = 2,
    parameter int DATA_W  = 8,
    localparam int WORD_W = field_w(WPG),
    localparam int LINES  = ROWS * GROUPS,
    localparam int DEPTH  = LINES * WPG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_on,
    input  logic              we,
    input  logic [LINES-1:0]  local_wl,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (bank_on && we) begin
            for (int i = 0; i < LINES; i++) begin
                if (local_wl[i]) mem[i*WPG + int'(word_idx)] <= wdata;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (bank_on && !we) begin
            for (int i = 0; i < LINES; i++) begin
                if (local_wl[i]) rd_word = mem[i*WPG + int'(word_idx)];
            end
        end
    end

    // R6: a write in a selected bank always lands on exactly one segment
    p_write_segment_r6: assert property (@(posedge clk) disable iff (rst)
        (bank_on && we) |-> ($countones(local_wl) == 1));
endmodule

// File: rtl/banked_sram.sv
module banked_sram
    import sram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROWS      = 8,
    parameter int GROUPS    = 4,
    parameter int WPG       = 2,
    parameter int DATA_W    = 8,
    localparam int BANK_W   = field_w(NUM_BANKS),
    localparam int ROW_W    = field_w(ROWS),
    localparam int GRP_W    = field_w(GROUPS),
    localparam int WORD_W   = field_w(WPG),
    localparam int ADDR_W   = BANK_W + ROW_W + GRP_W + WORD_W,
    localparam int LINES    = ROWS * GROUPS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [GROUPS-1:0]    grp_en
);
    acc_kind_e         kind;
    logic [BANK_W-1:0] bank_idx;
    logic [ROW_W-1:0]  row_idx;
    logic [GRP_W-1:0]  grp_idx;
    logic [WORD_W-1:0] word_idx;

    logic [GROUPS-1:0] grp_act [NUM_BANKS];
    logic [DATA_W-1:0] rd_word [NUM_BANKS];
    logic [DATA_W-1:0] rd_merge;

    assign kind = classify(rst, req, we);

    sram_addr_split #(
        .NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .GROUPS(GROUPS), .WPG(WPG)
    ) u_split (
        .addr(addr), .bank_idx(bank_idx), .row_idx(row_idx),
        .grp_idx(grp_idx), .word_idx(word_idx)
    );

    sram_bank_select #(.NUM_BANKS(NUM_BANKS)) u_bsel (
        .kind(kind), .bank_idx(bank_idx), .bank_en(bank_en)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic [LINES-1:0] local_wl;

        sram_wordline_gate #(.ROWS(ROWS), .GROUPS(GROUPS)) u_gate (
            .clk(clk), .rst(rst), .bank_on(bank_en[k]),
            .row_idx(row_idx), .grp_idx(grp_idx),
            .local_wl(local_wl), .grp_act(grp_act[k])
        );

        sram_bank_array #(
            .ROWS(ROWS), .GROUPS(GROUPS), .WPG(WPG), .DATA_W(DATA_W)
        ) u_arr (
            .clk(clk), .rst(rst), .bank_on(bank_en[k]), .we(we),
            .local_wl(local_wl), .word_idx(word_idx),
            .wdata(wdata), .rd_word(rd_word[k])
        );
    end

    always_comb begin
        grp_en   = '0;
        rd_merge = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            grp_en   = grp_en | grp_act[k];
            rd_merge = rd_merge | rd_word[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    rdata <= '0;
        else if (kind == ACC_READ)  rdata <= rd_merge;
    end

    // R2: one bank, matching the top address field
    p_bank_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        req |-> ($countones(bank_en) == 1 && bank_en[addr[ADDR_W-1 -: BANK_W]]));

    // R3: one group, matching the group field
    p_group_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        req |-> ($countones(grp_en) == 1 && grp_en[addr[WORD_W +: GRP_W]]));

    // R4: no activity without a request
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !req |-> (bank_en == '0 && grp_en == '0));

    // R8: read data holds when no read is requested
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(req && !we) |=> $stable(rdata));
endmodule

// File: tb/tb_banked_sram.sv
module tb_banked_sram;
    localparam int NB = 4, NR = 8, NG = 4, NW = 2, DW = 8;
    localparam int AW = 8;
    localparam int DEPTH = NB * NR * NG * NW;

    logic clk = 1'b0;
    logic rst, req, we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic [NB-1:0] bank_en;
    logic [NG-1:0] grp_en;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DW-1:0] model [DEPTH];

    always #5 clk = ~clk;

    banked_sram #(.NUM_BANKS(NB), .ROWS(NR), .GROUPS(NG), .WPG(NW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bank_en(bank_en), .grp_en(grp_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int a);
        return DW'((a * 37 + 11) % 256);
    endfunction

    // one access; enables checked mid-cycle, read data after the edge
    task automatic access(input logic w, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = AW'(a); wdata = d;
        #1;
        check("R1/R2 bank_en", 32'(bank_en), 32'(1) << (a >> 6));
        check("R1/R3 grp_en", 32'(grp_en), 32'(1) << ((a >> 1) & 3));
        @(posedge clk); #1;
        req = 1'b0;
        if (w) model[a] = d;
        else check("R7 rdata", 32'(rdata), 32'(model[a]));
    endtask

    initial begin
        logic [DW-1:0] held;
        rst = 1'b1; req = 1'b1; we = 1'b0; addr = 8'hC5; wdata = '0;
        repeat (2) @(negedge clk);
        check("R5 bank_en in reset", 32'(bank_en), 0);
        check("R5 grp_en in reset", 32'(grp_en), 0);
        check("R5 rdata in reset", 32'(rdata), 0);
        rst = 1'b0; req = 1'b0;
        #1;
        check("R4 bank_en idle", 32'(bank_en), 0);
        check("R4 grp_en idle", 32'(grp_en), 0);

        for (int a = 0; a < DEPTH; a++) access(1'b1, a, pattern(a));
        for (int a = 0; a < DEPTH; a++) access(1'b0, a, '0);

        // R6: single-word overwrites, then sweep the same row in every bank
        for (int t = 0; t < 6; t++) begin
            int tgt;
            int row;
            tgt = (t * 83 + 29) % DEPTH;
            row = (tgt >> 3) & 7;
            access(1'b1, tgt, ~pattern(tgt));
            for (int b = 0; b < NB; b++)
                for (int c = 0; c < NG * NW; c++)
                    access(1'b0, (b << 6) | (row << 3) | c, '0);
        end

        // R8: read data holds across writes and idle cycles
        access(1'b0, 77, '0);
        held = model[77];
        access(1'b1, 78, 8'h5A);
        check("R8 rdata after write", 32'(rdata), 32'(held));
        repeat (3) @(negedge clk);
        check("R8 rdata after idle", 32'(rdata), 32'(held));
        check("R4 bank_en idle late", 32'(bank_en), 0);
        access(1'b0, 78, '0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule